// File: doc/BRIEF.md
# Two-Slot Receive Message Buffer Controller

This block keeps track of where accepted receive frames are placed in a controller for a CAN-style bus. An acceptance stage in front of it reports each admitted frame with a one-cycle pulse. With that pulse it gives two tags: the filter that matched (0 or 1) and whether the frame is a remote request. The controller picks one of two buffer slots for the frame. It records the tags and tells the payload memory, through a store strobe and a slot index, which slot to write.

Slot 0 is the primary target. When slot 0 is still occupied and software has enabled rollover, the frame goes to slot 1 instead. When neither slot can take the frame, the frame is dropped and a sticky overflow flag is raised. Software reads and writes a 16-bit status/control word for slot 0. It releases each slot with a dedicated clear strobe. Slot 1's occupancy and tags are visible on their own output pins. Payload storage, bit timing, frame decoding and acceptance filtering are handled elsewhere.

Top module: `rx_dual_slot`

## Requirements
- R1: After reset the status word reads 0x0000, and overflow, slot-1 full, slot-1 tags and store strobe are all 0.
- R2: An accepted frame arriving while slot 0 is empty is loaded into slot 0. On the next cycle three things are true. First, bit 7 of the status word (slot 0 full) reads 1. Second, bit 3 holds the remote-request tag and bit 0 holds the filter number. Third, store_stb is high for exactly one cycle with store_idx = 0.
- R3: An accepted frame arriving while slot 0 is full, bit 2 (rollover enable) is 1 and slot 1 is empty is loaded into slot 1. On the next cycle slot1_full = 1 and slot1_remote/slot1_filter hold its tags. A one-cycle store_stb appears with store_idx = 1. Slot 0's fields are left unchanged.
- R4: An accepted frame arriving while slot 0 is full and either rollover is disabled or slot 1 is full is discarded. On the next cycle overflow reads 1 and stays 1 until reset. No store strobe is issued, and no flag or tag of either slot changes.
- R5: A register write with bit 7 = 0 clears slot 0 full. A write with bit 7 = 1 leaves it unchanged. A clr_slot0 pulse also clears it. The bit 3 and bit 0 tags keep the last loaded values.
- R6: Bit 2 is read/write. Bit 1 always reads the same value as bit 2, and writes to bit 1 are ignored.
- R7: Bits 15..8 and 6..4 always read 0, even after writing ones to them. Bits 3 and 0 are not changed by register writes.
- R8: A clr_slot1 pulse clears slot1_full and leaves the slot-1 tags unchanged.
- R9: If a load and a software clear target the same slot in the same cycle, the load wins and the slot's full flag is 1 on the next cycle.
- R10: Slot selection uses the flags and rollover enable held at the start of the cycle. An accept arriving in the same cycle as a write that frees slot 0 sees slot 0 as still full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle pulse: a frame has been accepted |
| acc_filter | input | 1 | Filter number that admitted the frame |
| acc_remote | input | 1 | Frame is a remote request |
| reg_wr | input | 1 | Write strobe for the status/control word |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Status/control word of slot 0 |
| clr_slot0 | input | 1 | Software release of slot 0 |
| clr_slot1 | input | 1 | Software release of slot 1 |
| slot1_full | output | 1 | Slot 1 holds a message |
| slot1_remote | output | 1 | Remote-request tag of slot 1 |
| slot1_filter | output | 1 | Filter tag of slot 1 |
| overflow | output | 1 | Sticky: a frame was discarded |
| store_stb | output | 1 | One-cycle payload write request |
| store_idx | output | 1 | Slot the payload is written to |

## Verification
The assertions assume that acc_valid is sampled only on clock edges and that a frame's tags are valid whenever acc_valid is high. They also assume that the register write, the clear strobes and acceptances may all coincide in any combination. No further protocol is assumed between them. The stimulus changes every input at the falling edge only, so each cycle presents a single combination. It deliberately pairs accepts with clears and with register writes to reach the ordering cases in R9 and R10.

// File: rtl/rx_dual_slot.sv
module rx_dual_slot #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_filter,
  input  logic             acc_remote,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             clr_slot0,
  input  logic             clr_slot1,
  output logic             slot1_full,
  output logic             slot1_remote,
  output logic             slot1_filter,
  output logic             overflow,
  output logic             store_stb,
  output logic             store_idx
);

  localparam int B_FULL = 7;
  localparam int B_RTR  = 3;
  localparam int B_ROLL = 2;
  localparam int B_MIRR = 1;
  localparam int B_HIT  = 0;

  logic full0_q, rtr0_q, hit0_q, roll_q;
  logic full1_q, rtr1_q, hit1_q, ovf_q, stb_q, idx_q;

  wire sw_free0 = clr_slot0 | (reg_wr & ~reg_wdata[B_FULL]);
  wire load0    = acc_valid & ~full0_q;
  wire load1    = acc_valid & full0_q & roll_q & ~full1_q;
  wire discard  = acc_valid & ~load0 & ~load1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full0_q <= 1'b0;
      rtr0_q  <= 1'b0;
      hit0_q  <= 1'b0;
      roll_q  <= 1'b0;
    end else begin
      if (load0) begin
        full0_q <= 1'b1;
        rtr0_q  <= acc_remote;
        hit0_q  <= acc_filter;
      end else if (sw_free0) begin
        full0_q <= 1'b0;
      end
      if (reg_wr) roll_q <= reg_wdata[B_ROLL];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full1_q <= 1'b0;
      rtr1_q  <= 1'b0;
      hit1_q  <= 1'b0;
    end else if (load1) begin
      full1_q <= 1'b1;
      rtr1_q  <= acc_remote;
      hit1_q  <= acc_filter;
    end else if (clr_slot1) begin
      full1_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      stb_q <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q | discard;
      stb_q <= load0 | load1;
      idx_q <= load1;
    end
  end

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[B_FULL] = full0_q;
    reg_rdata[B_RTR]  = rtr0_q;
    reg_rdata[B_ROLL] = roll_q;
    reg_rdata[B_MIRR] = roll_q;
    reg_rdata[B_HIT]  = hit0_q;
  end

  assign slot1_full   = full1_q;
  assign slot1_remote = rtr1_q;
  assign slot1_filter = hit1_q;
  assign overflow     = ovf_q;
  assign store_stb    = stb_q;
  assign store_idx    = idx_q;

  assert_load_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !reg_rdata[B_FULL]) |=>
      (reg_rdata[B_FULL] && store_stb && !store_idx &&
       reg_rdata[B_RTR] == $past(acc_remote) && reg_rdata[B_HIT] == $past(acc_filter)));

  assert_rollover_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && reg_rdata[B_FULL] && reg_rdata[B_ROLL] && !slot1_full) |=>
      (slot1_full && store_stb && store_idx && $stable(reg_rdata[B_HIT]) &&
       slot1_remote == $past(acc_remote)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && reg_rdata[B_FULL] && (!reg_rdata[B_ROLL] || slot1_full)) |=>
      (overflow && !store_stb && $stable(slot1_remote) && $stable(slot1_filter)));

  assert_sticky_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb |-> $past(acc_valid));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !reg_rdata[B_FULL] && clr_slot0) |=> reg_rdata[B_FULL]);

  assert_hold_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[B_FULL] && !clr_slot0 && !(reg_wr && !reg_wdata[B_FULL])) |=> reg_rdata[B_FULL]);

endmodule

// File: tb/rx_dual_slot_tb.sv
module rx_dual_slot_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic        acc;
    logic        filt;
    logic        rem;
    logic        wr;
    logic [15:0] wdata;
    logic        c0;
    logic        c1;
    logic [15:0] e_rd;
    logic        e_f1;
    logic        e_r1;
    logic        e_h1;
    logic        e_stb;
    logic        e_idx;
    logic        e_ovf;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0,16'h0081,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0}, // R2
    '{1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,16'h0081,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 one-cycle strobe
    '{1'b1,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b0,16'h0081,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R4 rollover off
    '{1'b0,1'b0,1'b0,1'b1,16'h0084,1'b0,1'b0,16'h0087,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R5 R6
    '{1'b1,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b0,16'h0087,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1}, // R3
    '{1'b1,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0,16'h0087,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1}, // R4 both full
    '{1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,16'h0007,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1}, // R5 clr strobe
    '{1'b1,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b0,16'h008E,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1}, // R2 reload
    '{1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b1,16'h008E,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1}, // R8
    '{1'b0,1'b0,1'b0,1'b1,16'hFF7B,1'b0,1'b0,16'h0008,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1}, // R7 R6 R5
    '{1'b1,1'b1,1'b1,1'b0,16'h0000,1'b1,1'b0,16'h0089,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1}, // R9
    '{1'b1,1'b0,1'b0,1'b1,16'h0000,1'b0,1'b0,16'h0009,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1}  // R10
  };

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_filter, acc_remote, reg_wr, clr_slot0, clr_slot1;
  logic [15:0] reg_wdata, reg_rdata;
  logic slot1_full, slot1_remote, slot1_filter, overflow, store_stb, store_idx;
  int n_checks = 0;
  int n_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dual_slot #(.REG_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_filter(acc_filter),
    .acc_remote(acc_remote), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clr_slot0(clr_slot0), .clr_slot1(clr_slot1),
    .slot1_full(slot1_full), .slot1_remote(slot1_remote), .slot1_filter(slot1_filter),
    .overflow(overflow), .store_stb(store_stb), .store_idx(store_idx)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic f, input logic r, input logic w,
                       input logic [15:0] d, input logic c0, input logic c1);
    acc_valid = a; acc_filter = f; acc_remote = r;
    reg_wr = w; reg_wdata = d; clr_slot0 = c0; clr_slot1 = c1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    drive(0,0,0,0,16'h0,0,0);
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    check("R1", "rdata", reg_rdata, 16'h0000);
    check("R1", "slot1 flags", {13'b0, slot1_full, slot1_remote, slot1_filter}, 16'h0);
    check("R1", "ovf/stb", {14'b0, overflow, store_stb}, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].acc, VEC[i].filt, VEC[i].rem, VEC[i].wr, VEC[i].wdata, VEC[i].c0, VEC[i].c1);
      step();
      drive(0,0,0,0,16'h0,0,0);
      check("R2-vec", $sformatf("rdata v%0d", i), reg_rdata, VEC[i].e_rd);
      check("R3-vec", $sformatf("slot1 v%0d", i), {13'b0, slot1_full, slot1_remote, slot1_filter},
            {13'b0, VEC[i].e_f1, VEC[i].e_r1, VEC[i].e_h1});
      check("R2-vec", $sformatf("store v%0d", i), {14'b0, store_stb, store_idx},
            {14'b0, VEC[i].e_stb, VEC[i].e_idx});
      check("R4-vec", $sformatf("ovf v%0d", i), {15'b0, overflow}, {15'b0, VEC[i].e_ovf});
    end

    // R1: reset mid-run restores every flag
    do_reset();
    check("R1", "rdata after rerun reset", reg_rdata, 16'h0000);
    check("R1", "ovf after rerun reset", {15'b0, overflow}, 16'h0);

    // R9: load into slot 1 beats clr_slot1 in the same cycle
    drive(1,0,0,0,16'h0,0,0); step();
    drive(0,0,0,1,16'h0084,0,0); step();
    drive(1,1,1,0,16'h0,0,1); step();
    drive(0,0,0,0,16'h0,0,0);
    check("R9", "slot1 load beats clear", {13'b0, slot1_full, slot1_remote, slot1_filter}, 16'h0007);
    check("R3", "store idx slot1", {14'b0, store_stb, store_idx}, 16'h0003);
    step();
    check("R2", "strobe drops", {15'b0, store_stb}, 16'h0);

    // R6: writes to bit 1 alone do not set it
    drive(0,0,0,1,16'h0082,0,0); step();
    drive(0,0,0,0,16'h0,0,0);
    check("R6", "mirror ignores write", reg_rdata, 16'h0080);
    check("R4", "no overflow yet", {15'b0, overflow}, 16'h0);

    finish_run();
  end
endmodule